// File: doc/BRIEF.md
# Dual-Chip Readout Frame Capture

This block takes the digitized output of two front-end readout chips, each sampled by its own ADC on the common 40 MHz system clock, and turns every readout into one event of 16-bit words in an internal FIFO. A readout is framed by a data-valid strobe. Once the strobe is seen rising, one sample per clock arrives from each chip. The first samples of a frame are header slots, and the block discards them. The channel samples that follow are converted from sign-magnitude codes to two's complement words.

The two chips deliver their channels in parallel. The event, however, is laid out with every chip A channel first and then every chip B channel. Chip A words therefore go straight into the FIFO while chip B words wait in a side buffer, and the buffer is drained into the FIFO once the frame ends. The FIFO keeps a tentative write pointer apart from the pointer the consumer sees. A frame cut short by the strobe, or one that lost a word to a full FIFO, is rolled back and leaves no trace. A complete event becomes visible all at once, together with a one-cycle done pulse.

Top module: `dual_frame_capture`

## Requirements
- R1: A frame starts only in a cycle where data_valid is sampled high after being low the cycle before, while no frame is being captured or drained. A level held high, or a rise during capture or drain, starts nothing.
- R2: A frame has HDR_LEN + CH_LEN slots, one per clock, counted from the starting cycle. The samples in the first HDR_LEN slots are dropped.
- R3: An event holds 2*CH_LEN words in this order: chip A channel 0 up to CH_LEN-1, then chip B channel 0 up to CH_LEN-1.
- R4: An ADC code is sign-magnitude. Bit 9 is the sign (1 = negative) and bits 8:0 are the magnitude in mV. The stored word is the 16-bit two's complement of +magnitude or -magnitude, and a negative zero is stored as 0.
- R5: If data_valid is low in a slot before the last one, frame_trunc pulses for one cycle on the following cycle. None of that frame's words ever reach out_data, and events stored earlier are unchanged.
- R6: The words of an event become readable only once all of them are written. frame_done pulses for one cycle, in the same cycle that out_valid first reflects the event, CH_LEN cycles after the cycle that took the last slot.
- R7: A word written while the FIFO is full is dropped and sets overflow, which stays high until reset. The event it belonged to is discarded and gives no frame_done.
- R8: out_valid is high while a complete event word is stored. out_data shows the oldest such word, and out_ready with out_valid removes it. While out_valid is high and out_ready low, out_data holds.
- R9: While reset is applied, out_valid, frame_done, frame_trunc and overflow are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz system clock, also the ADC sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_valid | input | 1 | Readout strobe from the front-end chips |
| adc_a | input | ADC_W | Sample code from chip A's ADC |
| adc_b | input | ADC_W | Sample code from chip B's ADC |
| out_ready | input | 1 | Consumer pops the current word |
| out_data | output | WORD_W | Oldest committed event word |
| out_valid | output | 1 | A committed word is available |
| frame_done | output | 1 | One-cycle pulse when an event becomes readable |
| frame_trunc | output | 1 | One-cycle pulse when a frame is cut short |
| overflow | output | 1 | Sticky: a write met a full FIFO |

## Verification
The bench builds the block with HDR_LEN = 4, CH_LEN = 8 and FIFO_DEPTH = 32. A frame then lasts 12 slots and an event is 16 words, so exactly two events fill the FIFO. This makes the corner cases cheap to reach: a truncated frame sitting between two stored events, a third event that meets a full FIFO at its first channel write, and a rise on the strobe during the drain. Every word of every event is checked, including sign, magnitude, negative zero and the A-then-B order.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_IDLE  = 2'd0,
    FC_CAPT  = 2'd1,
    FC_DRAIN = 2'd2
  } fc_state_e;
endpackage

// File: rtl/fc_sample_conv.sv
module fc_sample_conv #(
  parameter int IN_W  = 10,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  code,
  output logic [OUT_W-1:0] word
);
  localparam int PAD = OUT_W - IN_W + 1;
  logic [OUT_W-1:0] mag_ext;

  always_comb begin
    mag_ext = {{PAD{1'b0}}, code[IN_W-2:0]};
    word    = code[IN_W-1] ? (~mag_ext + OUT_W'(1)) : mag_ext;
  end
endmodule

// File: rtl/fc_chan_buf.sv
module fc_chan_buf #(
  parameter int DEPTH = 128,
  parameter int W     = 16
) (
  input  logic                     clk,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [W-1:0]             wr_data,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [W-1:0]             rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/fc_commit_fifo.sv
module fc_commit_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         commit,
  input  logic         rewind,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_avail,
  output logic         drop,
  output logic         ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] spec_q, spec_d, cmt_q, cmt_d, rd_q, rd_d;
  logic          ovf_q, ovf_d;
  logic          full, do_wr, pop;

  always_comb begin
    full   = (spec_q - rd_q) == PW'(DEPTH);
    do_wr  = wr_en & ~full;
    drop   = wr_en & full;
    pop    = rd_en & rd_avail;
    spec_d = rewind ? cmt_q : spec_q + PW'(do_wr);
    cmt_d  = commit ? spec_q + PW'(do_wr) : cmt_q;
    rd_d   = rd_q + PW'(pop);
    ovf_d  = ovf_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spec_q <= '0;
      cmt_q  <= '0;
      rd_q   <= '0;
      ovf_q  <= 1'b0;
    end else begin
      spec_q <= spec_d;
      cmt_q  <= cmt_d;
      rd_q   <= rd_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[spec_q[AW-1:0]] <= wr_data;
  end

  assign rd_avail = cmt_q != rd_q;
  assign rd_data  = mem[rd_q[AW-1:0]];
  assign ovf      = ovf_q;
endmodule

// File: rtl/fc_frame_ctrl.sv
module fc_frame_ctrl
  import fc_pkg::*;
#(
  parameter int HDR = 16,
  parameter int CH  = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  dv,
  input  logic                  drop,
  output logic                  chan_wr,
  output logic [$clog2(CH)-1:0] chan_idx,
  output logic                  drain,
  output logic [$clog2(CH)-1:0] drain_idx,
  output logic                  fifo_wr,
  output logic                  commit,
  output logic                  rewind,
  output logic                  done,
  output logic                  trunc
);
  localparam int SLOTS = HDR + CH;
  localparam int CW    = $clog2(SLOTS + 1);
  localparam int IW    = $clog2(CH);

  fc_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d, slot, ofs;
  logic          dvq_q, bad_q, bad_d, done_q, trunc_q;
  logic          start, take, last_slot, cut, drain_last, bad_now;

  always_comb begin
    start      = (st_q == FC_IDLE) & dv & ~dvq_q;
    slot       = (st_q == FC_CAPT) ? cnt_q : '0;
    take       = start | ((st_q == FC_CAPT) & dv);
    chan_wr    = take & (slot >= CW'(HDR));
    ofs        = slot - CW'(HDR);
    chan_idx   = ofs[IW-1:0];
    last_slot  = take & (slot == CW'(SLOTS - 1));
    cut        = (st_q == FC_CAPT) & ~dv;
    drain      = (st_q == FC_DRAIN);
    drain_idx  = cnt_q[IW-1:0];
    drain_last = drain & (cnt_q == CW'(CH - 1));
    fifo_wr    = chan_wr | drain;
    bad_now    = bad_q | drop;
    commit     = drain_last & ~bad_now;
    rewind     = cut | (drain_last & bad_now);

    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      FC_IDLE: if (start) begin
        st_d  = FC_CAPT;
        cnt_d = CW'(1);
      end
      FC_CAPT: begin
        if (cut) begin
          st_d = FC_IDLE;
        end else if (last_slot) begin
          st_d  = FC_DRAIN;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      FC_DRAIN: begin
        if (drain_last) st_d = FC_IDLE;
        cnt_d = cnt_q + CW'(1);
      end
      default: st_d = FC_IDLE;
    endcase

    if (cut | drain_last)    bad_d = 1'b0;
    else if (start)          bad_d = drop;
    else if (st_q != FC_IDLE) bad_d = bad_now;
    else                     bad_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= FC_IDLE;
      cnt_q   <= '0;
      dvq_q   <= 1'b0;
      bad_q   <= 1'b0;
      done_q  <= 1'b0;
      trunc_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      dvq_q   <= dv;
      bad_q   <= bad_d;
      done_q  <= commit;
      trunc_q <= cut;
    end
  end

  assign done  = done_q;
  assign trunc = trunc_q;
endmodule

// File: rtl/dual_frame_capture.sv
module dual_frame_capture #(
  parameter int HDR_LEN    = 16,
  parameter int CH_LEN     = 128,
  parameter int ADC_W      = 10,
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_valid,
  input  logic [ADC_W-1:0]  adc_a,
  input  logic [ADC_W-1:0]  adc_b,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              frame_done,
  output logic              frame_trunc,
  output logic              overflow
);
  localparam int NCHIP = 2;
  localparam int IW    = $clog2(CH_LEN);

  logic [1:0]        rs_q;
  logic              rst_i;
  logic [ADC_W-1:0]  code [NCHIP];
  logic [WORD_W-1:0] word [NCHIP];
  logic [WORD_W-1:0] buf_rd, fifo_wd;
  logic [IW-1:0]     chan_idx, drain_idx;
  logic              chan_wr, drain, fifo_wr, commit, rewind, drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  assign code[0] = adc_a;
  assign code[1] = adc_b;

  for (genvar g = 0; g < NCHIP; g++) begin : g_conv
    fc_sample_conv #(.IN_W(ADC_W), .OUT_W(WORD_W)) u_conv (
      .code (code[g]),
      .word (word[g])
    );
  end

  fc_frame_ctrl #(.HDR(HDR_LEN), .CH(CH_LEN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_i),
    .dv        (data_valid),
    .drop      (drop),
    .chan_wr   (chan_wr),
    .chan_idx  (chan_idx),
    .drain     (drain),
    .drain_idx (drain_idx),
    .fifo_wr   (fifo_wr),
    .commit    (commit),
    .rewind    (rewind),
    .done      (frame_done),
    .trunc     (frame_trunc)
  );

  fc_chan_buf #(.DEPTH(CH_LEN), .W(WORD_W)) u_bbuf (
    .clk     (clk),
    .wr_en   (chan_wr),
    .wr_idx  (chan_idx),
    .wr_data (word[1]),
    .rd_idx  (drain_idx),
    .rd_data (buf_rd)
  );

  assign fifo_wd = drain ? buf_rd : word[0];

  fc_commit_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_i),
    .wr_en    (fifo_wr),
    .wr_data  (fifo_wd),
    .commit   (commit),
    .rewind   (rewind),
    .rd_en    (out_ready),
    .rd_data  (out_data),
    .rd_avail (out_valid),
    .drop     (drop),
    .ovf      (overflow)
  );
endmodule

// File: rtl/fc_capture_checker.sv
module fc_capture_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              data_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid,
  input logic              frame_done,
  input logic              frame_trunc,
  input logic              overflow
);
  // R5: a cut-short frame is only reported after a low strobe
  assert_trunc_after_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_trunc |-> !$past(data_valid));

  // R5: truncation pulse lasts one cycle
  assert_trunc_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_trunc |=> !frame_trunc);

  // R6: done pulse lasts one cycle and comes with readable data
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> out_valid);

  // R5/R6: one event cannot both finish and be cut
  assert_done_trunc_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_trunc));

  // R7: overflow is sticky
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8: an unconsumed word stays put
  assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind dual_frame_capture fc_capture_checker #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .data_valid  (data_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .frame_done  (frame_done),
  .frame_trunc (frame_trunc),
  .overflow    (overflow)
);

// File: tb/dual_frame_capture_tb.sv
`timescale 1ns/1ps
module dual_frame_capture_tb;
  localparam int HDR   = 4;
  localparam int CH    = 8;
  localparam int DEPTH = 32;
  localparam int SLOTS = HDR + CH;
  localparam logic [9:0] HDR_CODE = 10'h155;

  // {code_a, code_b, first word A, first word B}
  localparam logic [51:0] VEC [4] = '{
    {10'h005, 10'h205, 16'h0005, 16'hFFFB},
    {10'h1FF, 10'h3FF, 16'h01FF, 16'hFE01},
    {10'h200, 10'h000, 16'h0000, 16'h0000},
    {10'h2A0, 10'h0F0, 16'hFF60, 16'h00F0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        data_valid;
  logic [9:0]  adc_a, adc_b;
  logic        out_ready;
  logic [15:0] out_data;
  logic        out_valid, frame_done, frame_trunc, overflow;

  int total = 0;
  int fails = 0;
  int done_cnt = 0;
  int trunc_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dual_frame_capture #(
    .HDR_LEN(HDR), .CH_LEN(CH), .ADC_W(10), .WORD_W(16), .FIFO_DEPTH(DEPTH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .data_valid(data_valid),
    .adc_a(adc_a), .adc_b(adc_b), .out_ready(out_ready),
    .out_data(out_data), .out_valid(out_valid), .frame_done(frame_done),
    .frame_trunc(frame_trunc), .overflow(overflow)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      done_cnt  <= done_cnt + int'(frame_done);
      trunc_cnt <= trunc_cnt + int'(frame_trunc);
    end
  end

  function automatic logic [15:0] sm_word(input logic [9:0] c);
    int v;
    v = int'(c[8:0]);
    if (c[9]) v = -v;
    return 16'(v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drives nslots slots starting at a negedge; drops data_valid if drop_end
  task automatic drive_frame(input logic [9:0] ca, input logic [9:0] cb,
                             input int nslots, input bit drop_end);
    for (int s = 0; s < nslots; s++) begin
      data_valid = 1'b1;
      adc_a = (s < HDR) ? HDR_CODE : (ca ^ 10'(s - HDR));
      adc_b = (s < HDR) ? HDR_CODE : (cb ^ 10'(s - HDR));
      @(negedge clk);
    end
    if (drop_end) data_valid = 1'b0;
    adc_a = HDR_CODE;
    adc_b = HDR_CODE;
  endtask

  task automatic pop_event(input logic [9:0] ca, input logic [9:0] cb, input string req);
    for (int k = 0; k < 2*CH; k++) begin
      logic [15:0] e;
      e = (k < CH) ? sm_word(ca ^ 10'(k)) : sm_word(cb ^ 10'(k - CH));
      chk(out_valid == 1'b1, {req, " out_valid"}, int'(out_valid), 1);
      chk(out_data == e, {req, " word"}, int'(out_data), int'(e));
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int d0, t0;
    rst_n = 1'b0; data_valid = 1'b0; adc_a = '0; adc_b = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0,   "R9 out_valid",   int'(out_valid), 0);
    chk(frame_done == 1'b0,  "R9 frame_done",  int'(frame_done), 0);
    chk(frame_trunc == 1'b0, "R9 frame_trunc", int'(frame_trunc), 0);
    chk(overflow == 1'b0,    "R9 overflow",    int'(overflow), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R6
    for (int r = 0; r < 4; r++) begin
      logic [9:0] ca, cb;
      ca = VEC[r][51:42];
      cb = VEC[r][41:32];
      d0 = done_cnt;
      drive_frame(ca, cb, SLOTS, 1'b1);
      for (int c = 1; c <= CH; c++) begin
        @(negedge clk);
        if (c < CH) begin
          chk(out_valid == 1'b0, "R6 early out_valid", int'(out_valid), 0);
          chk(frame_done == 1'b0, "R6 early frame_done", int'(frame_done), 0);
        end else begin
          chk(out_valid == 1'b1, "R6 out_valid at done", int'(out_valid), 1);
          chk(frame_done == 1'b1, "R6 frame_done timing", int'(frame_done), 1);
        end
      end
      @(negedge clk);
      chk(done_cnt == d0 + 1, "R6 one done pulse", done_cnt, d0 + 1);
      chk(out_data == VEC[r][31:16], "R4 first A word", int'(out_data), int'(VEC[r][31:16]));
      pop_event(ca, cb, "R3/R4/R2 event");
      chk(out_valid == 1'b0, "R3 event length", int'(out_valid), 0);
      repeat (2) @(negedge clk);
    end

    // R5: truncated frame between two stored events
    drive_frame(10'h011, 10'h222, SLOTS, 1'b1);
    repeat (CH + 2) @(negedge clk);
    t0 = trunc_cnt; d0 = done_cnt;
    drive_frame(10'h0AA, 10'h2BB, HDR + 3, 1'b1);
    @(negedge clk);
    chk(frame_trunc == 1'b1, "R5 trunc pulse", int'(frame_trunc), 1);
    repeat (CH + 3) @(negedge clk);
    chk(trunc_cnt == t0 + 1, "R5 trunc count", trunc_cnt, t0 + 1);
    chk(done_cnt == d0, "R5 no done", done_cnt, d0);
    drive_frame(10'h033, 10'h244, SLOTS, 1'b1);
    repeat (CH + 2) @(negedge clk);
    pop_event(10'h011, 10'h222, "R5 earlier event");
    pop_event(10'h033, 10'h244, "R5 next event");
    chk(out_valid == 1'b0, "R5 no partial words", int'(out_valid), 0);

    // R1: strobe rises during drain and is then held high
    d0 = done_cnt;
    drive_frame(10'h066, 10'h277, SLOTS, 1'b0);
    repeat (2) @(negedge clk);
    data_valid = 1'b0;
    @(negedge clk);
    data_valid = 1'b1;
    repeat (3 * SLOTS) @(negedge clk);
    chk(done_cnt == d0 + 1, "R1 single event", done_cnt, d0 + 1);
    pop_event(10'h066, 10'h277, "R1 event");
    chk(out_valid == 1'b0, "R1 no extra frame", int'(out_valid), 0);
    chk(frame_trunc == 1'b0 && trunc_cnt == t0 + 1, "R1 no trunc", trunc_cnt, t0 + 1);
    data_valid = 1'b0;
    repeat (2) @(negedge clk);

    // R7: third event meets a full FIFO
    d0 = done_cnt;
    drive_frame(10'h101, 10'h302, SLOTS, 1'b1);
    repeat (CH + 2) @(negedge clk);
    drive_frame(10'h003, 10'h204, SLOTS, 1'b1);
    repeat (CH + 2) @(negedge clk);
    chk(overflow == 1'b0, "R7 no early overflow", int'(overflow), 0);
    drive_frame(10'h0C5, 10'h2C6, SLOTS, 1'b1);
    repeat (CH + 2) @(negedge clk);
    chk(overflow == 1'b1, "R7 overflow set", int'(overflow), 1);
    chk(done_cnt == d0 + 2, "R7 no done for dropped event", done_cnt, d0 + 2);
    pop_event(10'h101, 10'h302, "R7 first kept event");
    pop_event(10'h003, 10'h204, "R7 second kept event");
    chk(out_valid == 1'b0, "R7 dropped event discarded", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    chk(overflow == 1'b1, "R7 overflow sticky", int'(overflow), 1);

    // R8: data holds without out_ready
    drive_frame(10'h045, 10'h246, SLOTS, 1'b1);
    repeat (CH + 6) @(negedge clk);
    chk(out_data == sm_word(10'h045), "R8 hold word", int'(out_data), int'(sm_word(10'h045)));
    pop_event(10'h045, 10'h246, "R8 event");

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule